// File: doc/BRIEF.md
# Parallel ADC Host Interface Controller

This block lets on-chip logic drive a 12-bit successive-approximation converter that is reached over a parallel bus with a chip-enable strobe, an active-low chip-select, a read/convert select and a byte-address line. A single start request from the host makes the block run a whole transaction. It sets up the select lines, pulses chip-enable to begin a conversion, waits for the converter's status line to rise and then fall, runs a read cycle that samples the 12-bit data bus, and returns the formatted result together with a one-cycle valid strobe.

Every bus timing limit is counted in system-clock cycles, and each limit is a parameter. These are the select setup time, the chip-enable pulse width, the data access time, the byte-address hold time, the data-bus float time, the status-rise window and the two worst-case conversion times with a margin. The host picks either a full 12-bit conversion or a short 8-bit conversion for each request. A status line that never rises, or that stays high too long, ends the transaction with a timeout strobe in place of a result.

Top module: `adc_host_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip-enable is low, chip-select is high (inactive), busy, valid and error are low, and the result is zero.
- R2: A conversion drives chip-select low and read/convert low, with the byte-address at its cycle choice, for at least SETUP_CYC cycles before chip-enable rises. Chip-enable then stays high for at least CE_HIGH_CYC cycles, and byte-address stays stable while chip-enable is high.
- R3: The byte-address line during a conversion pulse equals the short-cycle select latched at the accepted start: 0 selects the full 12-bit cycle and 1 selects the short 8-bit cycle.
- R4: If the status line has not been seen high by the end of the window of STS_WIN_CYC cycles that follows the fall of the conversion chip-enable, error pulses and no read takes place. A status high seen during the pulse counts as seen.
- R5: After the status line has been seen high, it must fall within CONV_FULL_CYC+MARGIN_CYC cycles for a full cycle, or CONV_SHORT_CYC+MARGIN_CYC cycles for a short cycle. Otherwise error pulses and no read takes place.
- R6: A read drives chip-select low, read/convert high and byte-address low for at least SETUP_CYC cycles before chip-enable rises. Chip-enable then stays high for ACCESS_CYC cycles, the data bus is sampled at the last of those cycles, and byte-address stays low at the fall of chip-enable.
- R7: A full cycle reports all 12 sampled bits. A short cycle reports the upper 8 sampled bits, with the low 4 result bits forced to zero.
- R8: The valid output is a one-cycle strobe. The result output changes only on the cycle in which valid is high, and otherwise holds its value.
- R9: Busy rises on the cycle after a start request is accepted, stays high up to and including the valid or error cycle, and is low on the cycle after that.
- R10: A start request that arrives while busy is high is ignored. It starts no extra conversion, and its short-cycle select has no effect on the transaction already running.
- R11: The error output is a one-cycle strobe. After it, the block returns to idle with chip-enable low, and the result output keeps its previous value.
- R12: A start request is ignored until the float guard has expired. The guard is loaded with FLOAT_CYC-1 at the fall of the read chip-enable and counts down once per cycle. The next conversion chip-enable rises at least FLOAT_CYC cycles after that fall.
- R13: Chip-enable is never high while chip-select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Host start request, sampled on the rising clock edge |
| short_i | input | 1 | Short-cycle select, sampled with an accepted start (1 = 8-bit cycle) |
| busy_o | output | 1 | Transaction in progress |
| result_o | output | 12 | Last converted result |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| error_o | output | 1 | One-cycle strobe marking a status-line timeout |
| ce_o | output | 1 | Converter chip-enable strobe |
| cs_n_o | output | 1 | Converter chip-select, active low |
| rc_o | output | 1 | Converter read/convert select (1 = read, 0 = convert) |
| a0_o | output | 1 | Converter byte-address / cycle-length line |
| sts_i | input | 1 | Converter status, high while a conversion runs |
| db_i | input | 12 | Converter data bus |

## Verification
The bench builds the block with small cycle limits: 2 setup, 3 pulse, 4 access, 2 address hold, 5 float, a 4-cycle status window, and conversion limits of 20 and 14 cycles with a margin of 3. With these values, a converter model can place the status rise on the exact last accepted cycle of the window and on the first rejected one. It can also hold the status line for 20 cycles, which passes under the full-cycle limit and times out under the short-cycle limit. The small float value lets a restart land inside the float guard and then just after it expires. The model drives the data bus with inverted data until the access time is reached, so a read cycle that samples too early returns a wrong result.

// File: rtl/adc_host_pkg.sv
// Package adc_host_pkg
// Shared types and helper functions for the parallel ADC host controller.
// Assumes nothing beyond IEEE 1800-2017 constant-function support.
package adc_host_pkg;

    // Sequencer states: conversion setup/pulse, status handshake, read cycle, end states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CV_SETUP,
        ST_CV_PULSE,
        ST_STS_WAIT,
        ST_CONV,
        ST_RD_SETUP,
        ST_RD_ACCESS,
        ST_RD_HOLD,
        ST_DONE,
        ST_ERR
    } host_state_e;

    // Converter bus control lines grouped for one decode point.
    typedef struct packed {
        logic ce;
        logic cs_n;
        logic rc;
        logic a0;
    } bus_ctl_t;

    // Larger of two unsigned values, for sizing counters at elaboration.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_host_timer.sv
// Module adc_host_timer
// Loadable down counter that stops at zero and reports when it sits at zero.
// A load of N-1 makes the owner wait N cycles before done_o is seen.
// Assumes the load value fits in W bits.
module adc_host_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_q;

    // Count down toward zero; a load takes priority over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Done while the counter rests at zero.
    always_comb begin
        done_o = (cnt_q == '0);
    end

endmodule

// File: rtl/adc_host_capture.sv
// Module adc_host_capture
// Samples the converter data bus at the end of the read access and commits the
// formatted result when the transaction completes. Short cycles keep only the
// upper SHORT_W bits and zero the rest.
// Assumes SHORT_W <= DATA_W and that sample_i precedes commit_i in a transaction.
module adc_host_capture #(
    parameter int DATA_W  = 12,
    parameter int SHORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_i,
    input  logic              commit_i,
    input  logic              short_i,
    input  logic [DATA_W-1:0] db_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int LOW_W = DATA_W - SHORT_W;

    logic [DATA_W-1:0] raw_q;
    logic [DATA_W-1:0] fmt_short;
    logic [DATA_W-1:0] result_q;

    // Hold the raw bus word taken at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (sample_i) begin
            raw_q <= db_i;
        end
    end

    // Build the short-cycle view of the raw word.
    generate
        if (LOW_W > 0) begin : g_trunc
            always_comb begin
                fmt_short = {raw_q[DATA_W-1:LOW_W], {LOW_W{1'b0}}};
            end
        end else begin : g_full
            always_comb begin
                fmt_short = raw_q;
            end
        end
    endgenerate

    // Commit the formatted result; it holds until the next commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (commit_i) begin
            result_q <= short_i ? fmt_short : raw_q;
        end
    end

    assign result_o = result_q;

endmodule

// File: rtl/adc_host_fsm.sv
// Module adc_host_fsm
// Transaction sequencer: accepts a start, runs the conversion strobe, the
// status handshake with its two timeouts, the read strobe, and ends with a
// valid or error strobe. Owns the bus control decode and drives the shared
// phase timer and the float-guard load.
// Assumes every cycle parameter is at least 1 and fits the timer width TW.
module adc_host_fsm
    import adc_host_pkg::*;
#(
    parameter int TW             = 10,
    parameter int SETUP_CYC      = 3,
    parameter int CE_HIGH_CYC    = 3,
    parameter int ACCESS_CYC     = 8,
    parameter int A0_HOLD_CYC    = 3,
    parameter int STS_WIN_CYC    = 12,
    parameter int CONV_FULL_CYC  = 500,
    parameter int CONV_SHORT_CYC = 400,
    parameter int MARGIN_CYC     = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          short_i,
    input  logic          sts_i,
    input  logic          tmr_done_i,
    input  logic          grd_done_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          grd_load_o,
    output logic          sample_o,
    output logic          commit_o,
    output logic          short_o,
    output logic          ce_o,
    output logic          cs_n_o,
    output logic          rc_o,
    output logic          a0_o,
    output logic          busy_o,
    output logic          valid_o,
    output logic          error_o
);

    localparam logic [TW-1:0] SETUP_LD   = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] PULSE_LD   = TW'(CE_HIGH_CYC - 1);
    localparam logic [TW-1:0] ACCESS_LD  = TW'(ACCESS_CYC - 1);
    localparam logic [TW-1:0] HOLD_LD    = TW'(A0_HOLD_CYC - 1);
    localparam logic [TW-1:0] WIN_LD     = TW'(STS_WIN_CYC - 1);
    localparam logic [TW-1:0] FULL_LD    = TW'(CONV_FULL_CYC + MARGIN_CYC - 1);
    localparam logic [TW-1:0] SHORT_LD   = TW'(CONV_SHORT_CYC + MARGIN_CYC - 1);

    host_state_e st_q, st_d;
    logic        short_q;
    logic        sts_seen_q;
    logic        accept;
    bus_ctl_t    bus;

    // A start is taken only from idle and only once the float guard has run out.
    always_comb begin
        accept = (st_q == ST_IDLE) && start_i && grd_done_i;
    end

    // Next-state, phase-timer load and capture controls.
    always_comb begin
        st_d       = st_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        grd_load_o = 1'b0;
        sample_o   = 1'b0;
        commit_o   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    st_d       = ST_CV_SETUP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SETUP_LD;
                end
            end
            ST_CV_SETUP: begin
                if (tmr_done_i) begin
                    st_d       = ST_CV_PULSE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = PULSE_LD;
                end
            end
            ST_CV_PULSE: begin
                if (tmr_done_i) begin
                    st_d       = ST_STS_WAIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = WIN_LD;
                end
            end
            ST_STS_WAIT: begin
                if (sts_i || sts_seen_q) begin
                    st_d       = ST_CONV;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = short_q ? SHORT_LD : FULL_LD;
                end else if (tmr_done_i) begin
                    st_d = ST_ERR;
                end
            end
            ST_CONV: begin
                if (!sts_i) begin
                    st_d       = ST_RD_SETUP;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = SETUP_LD;
                end else if (tmr_done_i) begin
                    st_d = ST_ERR;
                end
            end
            ST_RD_SETUP: begin
                if (tmr_done_i) begin
                    st_d       = ST_RD_ACCESS;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = ACCESS_LD;
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_done_i) begin
                    st_d       = ST_RD_HOLD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = HOLD_LD;
                    sample_o   = 1'b1;
                    grd_load_o = 1'b1;
                end
            end
            ST_RD_HOLD: begin
                if (tmr_done_i) begin
                    st_d     = ST_DONE;
                    commit_o = 1'b1;
                end
            end
            ST_DONE: st_d = ST_IDLE;
            ST_ERR:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Latch the cycle length with the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            short_q <= 1'b0;
        end else if (accept) begin
            short_q <= short_i;
        end
    end

    // Remember a status rise that arrives while chip-enable is still high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_seen_q <= 1'b0;
        end else if (accept) begin
            sts_seen_q <= 1'b0;
        end else if (st_q == ST_CV_PULSE && sts_i) begin
            sts_seen_q <= 1'b1;
        end
    end

    // Bus line decode from the state register.
    always_comb begin
        bus = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, a0: 1'b0};
        case (st_q)
            ST_CV_SETUP:  bus = '{ce: 1'b0, cs_n: 1'b0, rc: 1'b0, a0: short_q};
            ST_CV_PULSE:  bus = '{ce: 1'b1, cs_n: 1'b0, rc: 1'b0, a0: short_q};
            ST_RD_SETUP:  bus = '{ce: 1'b0, cs_n: 1'b0, rc: 1'b1, a0: 1'b0};
            ST_RD_ACCESS: bus = '{ce: 1'b1, cs_n: 1'b0, rc: 1'b1, a0: 1'b0};
            default:      bus = '{ce: 1'b0, cs_n: 1'b1, rc: 1'b1, a0: 1'b0};
        endcase
    end

    assign ce_o    = bus.ce;
    assign cs_n_o  = bus.cs_n;
    assign rc_o    = bus.rc;
    assign a0_o    = bus.a0;
    assign short_o = short_q;
    assign busy_o  = (st_q != ST_IDLE);
    assign valid_o = (st_q == ST_DONE);
    assign error_o = (st_q == ST_ERR);

endmodule

// File: rtl/adc_host_ctrl.sv
// Module adc_host_ctrl
// Top of the parallel ADC host controller. Ties the sequencer to a shared phase
// timer, a float-guard timer and the result capture.
// Assumes the converter bus timings have been turned into clock-cycle counts
// (default values suit a 20 ns clock) and that sts_i and db_i are synchronous.
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DATA_W         = 12,
    parameter int SHORT_W        = 8,
    parameter int SETUP_CYC      = 3,
    parameter int CE_HIGH_CYC    = 3,
    parameter int ACCESS_CYC     = 8,
    parameter int A0_HOLD_CYC    = 3,
    parameter int FLOAT_CYC      = 8,
    parameter int STS_WIN_CYC    = 12,
    parameter int CONV_FULL_CYC  = 500,
    parameter int CONV_SHORT_CYC = 400,
    parameter int MARGIN_CYC     = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              short_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] result_o,
    output logic              valid_o,
    output logic              error_o,
    output logic              ce_o,
    output logic              cs_n_o,
    output logic              rc_o,
    output logic              a0_o,
    input  logic              sts_i,
    input  logic [DATA_W-1:0] db_i
);

    localparam int unsigned MAX_PHASE = max_u(max_u(max_u(SETUP_CYC, CE_HIGH_CYC),
                                                    max_u(ACCESS_CYC, A0_HOLD_CYC)),
                                              max_u(STS_WIN_CYC,
                                                    max_u(CONV_FULL_CYC, CONV_SHORT_CYC) + MARGIN_CYC));
    localparam int TW = $clog2(MAX_PHASE + 1);
    localparam int FW = $clog2(FLOAT_CYC + 1);
    localparam logic [FW-1:0] FLOAT_LD = FW'(FLOAT_CYC - 1);

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          grd_load;
    logic          grd_done;
    logic          sample;
    logic          commit;
    logic          short_q;

    adc_host_fsm #(
        .TW             (TW),
        .SETUP_CYC      (SETUP_CYC),
        .CE_HIGH_CYC    (CE_HIGH_CYC),
        .ACCESS_CYC     (ACCESS_CYC),
        .A0_HOLD_CYC    (A0_HOLD_CYC),
        .STS_WIN_CYC    (STS_WIN_CYC),
        .CONV_FULL_CYC  (CONV_FULL_CYC),
        .CONV_SHORT_CYC (CONV_SHORT_CYC),
        .MARGIN_CYC     (MARGIN_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .short_i    (short_i),
        .sts_i      (sts_i),
        .tmr_done_i (tmr_done),
        .grd_done_i (grd_done),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .grd_load_o (grd_load),
        .sample_o   (sample),
        .commit_o   (commit),
        .short_o    (short_q),
        .ce_o       (ce_o),
        .cs_n_o     (cs_n_o),
        .rc_o       (rc_o),
        .a0_o       (a0_o),
        .busy_o     (busy_o),
        .valid_o    (valid_o),
        .error_o    (error_o)
    );

    adc_host_timer #(.W(TW)) u_phase_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    adc_host_timer #(.W(FW)) u_float_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (grd_load),
        .load_val_i (FLOAT_LD),
        .done_o     (grd_done)
    );

    adc_host_capture #(
        .DATA_W  (DATA_W),
        .SHORT_W (SHORT_W)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .commit_i (commit),
        .short_i  (short_q),
        .db_i     (db_i),
        .result_o (result_o)
    );

endmodule

// File: rtl/adc_host_ctrl_chk.sv
// Module adc_host_ctrl_chk
// Protocol checker bound to adc_host_ctrl; observes ports only.
// Assumes CE_HIGH_CYC and ACCESS_CYC are at least 1.
module adc_host_ctrl_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic [DATA_W-1:0] result_o,
    input logic              valid_o,
    input logic              error_o,
    input logic              ce_o,
    input logic              cs_n_o,
    input logic              rc_o,
    input logic              a0_o
);

    AST_CE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) ce_o |-> !cs_n_o); // R13
    AST_CONV_A0_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (ce_o && !rc_o) |-> $stable(a0_o)); // R2
    AST_RD_A0_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ($fell(ce_o) && $past(rc_o)) |-> ($stable(a0_o) && !a0_o)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) valid_o |=> !valid_o); // R8
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result_o) |-> valid_o); // R8
    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n) (valid_o || error_o) |=> !busy_o); // R9
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(start_i)); // R9
    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(valid_o && error_o)); // R11
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) error_o |=> (!error_o && !ce_o)); // R11

endmodule

bind adc_host_ctrl adc_host_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .result_o (result_o),
    .valid_o  (valid_o),
    .error_o  (error_o),
    .ce_o     (ce_o),
    .cs_n_o   (cs_n_o),
    .rc_o     (rc_o),
    .a0_o     (a0_o)
);

// File: tb/sim_adc_host_ctrl.sv
// Bench for adc_host_ctrl: a converter model on the bus, a vector table walked
// by one loop, then directed tests for reset, busy, float guard and hold.
module sim_adc_host_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SETUP      = 2;
    localparam int CE_HIGH    = 3;
    localparam int ACCESS     = 4;
    localparam int A0_HOLD    = 2;
    localparam int FLOAT      = 5;
    localparam int STS_WIN    = 4;
    localparam int CONV_FULL  = 20;
    localparam int CONV_SHORT = 14;
    localparam int MARGIN     = 3;

    typedef struct packed {
        logic        sh;
        logic [11:0] data;
        logic [7:0]  dly;
        logic [7:0]  conv;
        logic        err;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 12'hA5C, 8'd1, 8'd20, 1'b0},
        '{1'b1, 12'hFFF, 8'd5, 8'd12, 1'b0},
        '{1'b0, 12'h000, 8'd3, 8'd10, 1'b0},
        '{1'b0, 12'hFFF, 8'd7, 8'd10, 1'b0},
        '{1'b1, 12'h123, 8'd2, 8'd8,  1'b0},
        '{1'b0, 12'h5A5, 8'd8, 8'd10, 1'b1},
        '{1'b1, 12'h777, 8'd5, 8'd20, 1'b1},
        '{1'b0, 12'h9C3, 8'd2, 8'd40, 1'b1},
        '{1'b0, 12'h3C7, 8'd6, 8'd15, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        short_sel;
    logic        busy, valid, error_s;
    logic [11:0] result;
    logic        ce, cs_n, rc, a0;
    logic        sts = 1'b0;
    logic [11:0] db = 12'h000;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_host_ctrl #(
        .DATA_W(12), .SHORT_W(8), .SETUP_CYC(SETUP), .CE_HIGH_CYC(CE_HIGH),
        .ACCESS_CYC(ACCESS), .A0_HOLD_CYC(A0_HOLD), .FLOAT_CYC(FLOAT),
        .STS_WIN_CYC(STS_WIN), .CONV_FULL_CYC(CONV_FULL),
        .CONV_SHORT_CYC(CONV_SHORT), .MARGIN_CYC(MARGIN)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .short_i(short_sel),
        .busy_o(busy), .result_o(result), .valid_o(valid), .error_o(error_s),
        .ce_o(ce), .cs_n_o(cs_n), .rc_o(rc), .a0_o(a0), .sts_i(sts), .db_i(db)
    );

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    // Converter model parameters set per transaction.
    logic [11:0] m_data = 12'h000;
    logic [7:0]  m_dly = 8'd1;
    logic [7:0]  m_conv = 8'd10;
    logic        m_short = 1'b0;
    int conv_count = 0;
    int rd_count   = 0;
    int ce_hi = 0, cs_low = 0, gap = 1000, t = 0, rd_t = 0;
    logic ce_q = 1'b0, conv_on = 1'b0, in_read = 1'b0;

    // Converter model and bus timing monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            ce_q = 1'b0; conv_on = 1'b0; in_read = 1'b0; sts = 1'b0;
            cs_low = 0; gap = 1000;
        end else begin
            if (ce && !ce_q) begin
                ce_hi = 1;
                if (!rc) begin
                    conv_count++;
                    chk(cs_low >= SETUP, "R2 convert select setup", cs_low, SETUP);
                    chk(a0 == m_short, "R3 cycle length on byte-address", int'(a0), int'(m_short));
                    chk(gap >= FLOAT, "R12 float gap before conversion", gap, FLOAT);
                    conv_on = 1'b1; t = 0; in_read = 1'b0;
                end else begin
                    rd_count++;
                    chk(cs_low >= SETUP, "R6 read select setup", cs_low, SETUP);
                    chk(a0 == 1'b0, "R6 byte-address low in read", int'(a0), 0);
                    in_read = 1'b1; rd_t = 0;
                end
            end else if (ce) begin
                ce_hi++;
            end
            if (!ce && gap < 1000) gap++;
            if (!ce && ce_q) begin
                if (in_read) begin
                    chk(ce_hi >= ACCESS, "R6 read strobe width", ce_hi, ACCESS);
                    gap = 0;
                end else begin
                    chk(ce_hi >= CE_HIGH, "R2 convert strobe width", ce_hi, CE_HIGH);
                end
            end
            if (cs_n) cs_low = 0;
            else if (!ce) cs_low++;
            if (conv_on) begin
                t++;
                sts = (t >= int'(m_dly)) && (t < int'(m_dly) + int'(m_conv));
                if (t >= int'(m_dly) + int'(m_conv)) conv_on = 1'b0;
            end
            if (ce && rc && !cs_n && in_read) begin
                rd_t++;
                db = (rd_t >= ACCESS) ? m_data : ~m_data;
            end else begin
                db = ~m_data;
            end
            ce_q = ce;
        end
    end

    logic [11:0] exp_res = 12'h000;

    task automatic wait_end();
        for (int n = 0; n < 400 && !valid && !error_s; n++) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v);
        int rd0;
        logic [11:0] e;
        repeat (60) @(negedge clk);
        m_data = v.data; m_dly = v.dly; m_conv = v.conv; m_short = v.sh;
        rd0 = rd_count;
        start = 1'b1; short_sel = v.sh;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after accepted start", int'(busy), 1);
        wait_end();
        if (v.err) begin
            chk(error_s == 1'b1, "R4/R5 status timeout flagged", int'(error_s), 1);
            chk(result == exp_res, "R11 result kept on timeout", result, exp_res);
            chk(rd_count == rd0, "R11 no read after timeout", rd_count, rd0);
            @(negedge clk);
            chk(!error_s && !busy && !ce, "R11 error strobe ends in idle", int'({error_s, busy, ce}), 0);
        end else begin
            e = v.sh ? {v.data[11:4], 4'h0} : v.data;
            chk(valid == 1'b1, "R6 read completes with valid", int'(valid), 1);
            chk(result == e, "R7 result format", result, e);
            exp_res = e;
            @(negedge clk);
            chk(!valid && !busy, "R8 valid single cycle, R9 busy low", int'({valid, busy}), 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int c0;
        logic [11:0] hold;
        rst_n = 1'b0; start = 1'b0; short_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ce && cs_n && !busy && !valid && !error_s && result == 12'h000,
            "R1 state during reset", int'({ce, cs_n, busy, valid, error_s}), 8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ce && cs_n && !busy && !valid && !error_s && result == 12'h000,
            "R1 state after reset", int'({ce, cs_n, busy, valid, error_s}), 8);
        chk(!ce || !cs_n, "R13 idle strobe low", int'(ce), 0);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

        // R10: second start with a different length during a conversion.
        repeat (60) @(negedge clk);
        m_data = 12'h6E1; m_dly = 8'd2; m_conv = 8'd12; m_short = 1'b0;
        c0 = conv_count;
        start = 1'b1; short_sel = 1'b0;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        start = 1'b1; short_sel = 1'b1;
        @(negedge clk);
        start = 1'b0; short_sel = 1'b0;
        wait_end();
        chk(valid && result == 12'h6E1, "R10 start while busy ignored", result, 12'h6E1);
        chk(conv_count == c0 + 1, "R10 single conversion", conv_count, c0 + 1);

        // R12: restart right after completion falls inside the float guard.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R12 start during float guard ignored", int'(busy), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R12 start accepted after guard", int'(busy), 1);
        wait_end();
        chk(valid && result == 12'h6E1, "R12 restarted conversion result", result, 12'h6E1);

        // R8: result holds between strobes.
        hold = result;
        repeat (15) @(negedge clk);
        chk(result == hold && !valid, "R8 result holds without valid", result, hold);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule